// File: doc/BRIEF.md
# IrDA SIR Pulse Modulator

This block turns bytes into the slow-infrared line format and drives an active-high LED line with short return-to-zero pulses. Each byte becomes a ten-bit frame: a start bit of zero, eight data bits with the least significant bit first, and a stop bit of one. A zero bit produces one pulse at the start of its bit cell. A one bit leaves the line dark. Between frames the line is low.

The block runs from one 48 MHz clock. Bit cells are timed by a fractional phase accumulator that adds the bit rate every cycle and wraps at the clock frequency, so the average cell length is exact and any single cell is within one clock of its ideal length. A rate code selects the bit rate. The pulse is either three sixteenths of the bit cell, or a programmed number of clock cycles that does not depend on the rate. Rate, mode and width are captured when a byte is accepted and hold for the whole frame.

Top module: `sir_tx_modulator`

## Requirements
- R1: After reset, `led_out` is low and `in_ready` is high.
- R2: `in_ready` is high only while no frame is in progress. It goes low in the cycle after a byte is accepted (`in_valid` and `in_ready` high at a clock edge). It returns high in the cycle that follows the bit tick ending the stop cell. A `in_valid` asserted while `in_ready` is low has no effect on the line.
- R3: A frame is a start bit (0), then data bits 0 to 7, then a stop bit (1). Each zero bit gives exactly one high pulse, starting at the first cycle of its bit cell. One bits, stop bits and idle time keep `led_out` low.
- R4: Take A as the accepting edge and bps as the selected rate. Bit cell k (k = 0 for the start bit, k = 10 for the end of the stop cell) begins at edge A + 1 + ceil(k * 48e6 / bps). The bit timing has no cumulative drift.
- R5: `rate_sel` codes map to bit rates as follows: 0 = 2400, 1 = 4800, 2 = 9600, 3 = 19200, 4 = 38400, 5 = 57600, 6 = 115200, 7 = 115200.
- R6: With `mode_fixed` = 0, each pulse lasts floor(3 * 48e6 / (16 * bps)) clock cycles. This is 78 cycles at 115200 bps and 937 cycles at 9600 bps.
- R7: With `mode_fixed` = 1, each pulse lasts `fixed_width` clock cycles. A code of 0 selects the default of 78 cycles (about 1.625 us).
- R8: A pulse width larger than floor(48e6 / bps) - 1 cycles is clipped to that value. This leaves at least one dark cycle before the next bit cell.
- R9: Rate, mode and width are sampled only at the accepting edge. Changes to `rate_sel`, `mode_fixed` and `fixed_width` during a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | 8 | Byte to transmit |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | High when the block can accept a byte (idle) |
| rate_sel | input | 3 | Bit-rate code (see R5) |
| mode_fixed | input | 1 | 0 = 3/16-cell pulse, 1 = fixed-count pulse |
| fixed_width | input | 12 | Fixed pulse width in clock cycles; 0 selects 78 |
| led_out | output | 1 | Active-high infrared LED drive |

## Verification
Every result is due at a cycle that the bench computes from the accepting edge A. `in_ready` falls in the interval right after A. The pulse for bit k is high from edge A + 1 + ceil(k * 48e6 / bps) for exactly the effective width, and `in_ready` rises after edge A + 1 + ceil(10 * 48e6 / bps). The bench samples both outputs at every falling clock edge from A to that end point and compares each sample with the waveform predicted from the requirements, so a pulse that is one cycle early, late, long or short is caught. During each frame the configuration inputs are scrambled and a second byte is offered, and the expected waveform still uses the values captured at A.

// File: rtl/sir_pkg.sv
package sir_pkg;

  localparam int unsigned BPS_W   = 17;
  localparam int unsigned MIN_BPS = 2400;

  // Rate code to bit rate; code 7 is an alias of the top rate.
  function automatic int unsigned sel_to_bps(input logic [2:0] code);
    int unsigned r;
    case (code)
      3'd0:    r = 2400;
      3'd1:    r = 4800;
      3'd2:    r = 9600;
      3'd3:    r = 19200;
      3'd4:    r = 38400;
      3'd5:    r = 57600;
      default: r = 115200;
    endcase
    return r;
  endfunction

  // Three sixteenths of one bit cell, in clock cycles (rounded down).
  function automatic int unsigned prop_width(input int unsigned clk_hz,
                                             input int unsigned bps);
    return (3 * clk_hz) / (16 * bps);
  endfunction

  // Longest pulse that still leaves one dark cycle in the shortest cell.
  function automatic int unsigned width_cap(input int unsigned clk_hz,
                                            input int unsigned bps);
    return (clk_hz / bps) - 1;
  endfunction

  // Effective pulse width for a frame.
  function automatic int unsigned pick_width(input int unsigned clk_hz,
                                             input int unsigned bps,
                                             input logic        fixed_mode,
                                             input int unsigned code,
                                             input int unsigned def_w);
    int unsigned w;
    int unsigned cap;
    if (fixed_mode) w = (code == 0) ? def_w : code;
    else            w = prop_width(clk_hz, bps);
    cap = width_cap(clk_hz, bps);
    return (w > cap) ? cap : w;
  endfunction

endpackage

// File: rtl/sir_baud_acc.sv
module sir_baud_acc #(
  parameter int unsigned CLK_HZ = 48_000_000,
  parameter int unsigned INC_W  = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [INC_W-1:0] load_inc,
  input  logic             run,
  input  logic [INC_W-1:0] inc,
  output logic             tick
);

  localparam int unsigned ACC_W = $clog2(CLK_HZ);
  localparam int unsigned SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] acc;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] wrap;

  always_comb begin
    sum  = {1'b0, acc} + SUM_W'(inc);
    wrap = sum - SUM_W'(CLK_HZ);
    tick = run && (sum >= SUM_W'(CLK_HZ));
  end

  // Loading one step short of the wrap point makes the first tick fall
  // in the cycle right after acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (load) begin
      acc <= ACC_W'(SUM_W'(CLK_HZ) - SUM_W'(load_inc));
    end else if (tick) begin
      acc <= wrap[ACC_W-1:0];
    end else if (run) begin
      acc <= sum[ACC_W-1:0];
    end
  end

endmodule

// File: rtl/sir_frame_seq.sv
module sir_frame_seq #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] data,
  input  logic              tick,
  output logic              busy,
  output logic              pulse_start
);

  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned IDX_W   = $clog2(FRAME_W + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W);

  logic [FRAME_W-1:0] shreg;
  logic [IDX_W-1:0]   idx;
  logic               end_tick;

  always_comb begin
    end_tick    = busy && tick && (idx == LAST_IDX);
    pulse_start = busy && tick && (idx != LAST_IDX) && !shreg[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
      idx   <= '0;
      busy  <= 1'b0;
    end else if (accept) begin
      shreg <= {1'b1, data, 1'b0};
      idx   <= '0;
      busy  <= 1'b1;
    end else if (end_tick) begin
      busy  <= 1'b0;
    end else if (busy && tick) begin
      shreg <= {1'b1, shreg[FRAME_W-1:1]};
      idx   <= idx + 1'b1;
    end
  end

endmodule

// File: rtl/sir_pulse_timer.sv
module sir_pulse_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] width,
  output logic             led
);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (start) begin
      remain <= width;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign led = (remain != '0);

endmodule

// File: rtl/sir_tx_modulator.sv
module sir_tx_modulator #(
  parameter int unsigned CLK_HZ = 48_000_000,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned PW_W   = 12,
  parameter int unsigned DEF_PW = 78
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SEL_W-1:0]  rate_sel,
  input  logic              mode_fixed,
  input  logic [PW_W-1:0]   fixed_width,
  output logic              led_out
);

  import sir_pkg::*;

  localparam int unsigned CNT_W = $clog2(CLK_HZ / MIN_BPS) + 1;

  logic             busy;
  logic             accept;
  logic             bit_tick;
  logic             pulse_start;
  logic [BPS_W-1:0] new_bps;
  logic [CNT_W-1:0] new_width;
  logic [BPS_W-1:0] cfg_bps;
  logic [CNT_W-1:0] cfg_width;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  always_comb begin
    new_bps   = BPS_W'(sel_to_bps(3'(rate_sel)));
    new_width = CNT_W'(pick_width(CLK_HZ, 32'(new_bps), mode_fixed,
                                  32'(fixed_width), DEF_PW));
  end

  // Frame configuration, captured only at acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_bps   <= BPS_W'(115200);
      cfg_width <= CNT_W'(DEF_PW);
    end else if (accept) begin
      cfg_bps   <= new_bps;
      cfg_width <= new_width;
    end
  end

  sir_baud_acc #(.CLK_HZ(CLK_HZ), .INC_W(BPS_W)) u_baud (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_inc (new_bps),
    .run      (busy),
    .inc      (cfg_bps),
    .tick     (bit_tick)
  );

  sir_frame_seq #(.DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .data        (in_data),
    .tick        (bit_tick),
    .busy        (busy),
    .pulse_start (pulse_start)
  );

  sir_pulse_timer #(.CNT_W(CNT_W)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .start (pulse_start),
    .width (cfg_width),
    .led   (led_out)
  );

endmodule

// File: rtl/sir_tx_modulator_chk.sv
module sir_tx_modulator_chk #(
  parameter int unsigned CLK_HZ = 48_000_000,
  parameter int unsigned BPS_W  = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             led_out,
  input logic             bit_tick,
  input logic [BPS_W-1:0] cfg_bps
);

  logic [31:0] hi_len;
  logic [31:0] cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_len <= '0;
    else if (led_out) hi_len <= hi_len + 1;
    else              hi_len <= '0;
  end

  assign cap = sir_pkg::width_cap(CLK_HZ, 32'(cfg_bps));

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);  // R2

  AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !led_out);  // R3

  AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(led_out) |-> $past(bit_tick));  // R3

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);  // R4

  AST_PULSE_CLIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    led_out |-> hi_len < cap);  // R8

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready && $past(!in_ready) |-> $stable(cfg_bps));  // R9

endmodule

bind sir_tx_modulator sir_tx_modulator_chk #(.CLK_HZ(CLK_HZ), .BPS_W(sir_pkg::BPS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .led_out  (led_out),
  .bit_tick (bit_tick),
  .cfg_bps  (cfg_bps)
);

// File: tb/sir_tx_modulator_test.sv
module sir_tx_modulator_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam longint CLK = 48_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  rate_sel = 3'd6;
  logic        mode_fixed = 1'b0;
  logic [11:0] fixed_width = '0;
  logic        led_out;

  int total = 0;
  int failed = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sir_tx_modulator uut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .rate_sel(rate_sel), .mode_fixed(mode_fixed),
    .fixed_width(fixed_width), .led_out(led_out)
  );

  function automatic longint b_bps(input logic [2:0] c);
    longint t [8] = '{2400, 4800, 9600, 19200, 38400, 57600, 115200, 115200};
    return t[c];
  endfunction

  function automatic longint b_width(input longint bps, input logic fx,
                                     input longint code);
    longint w;
    longint lim;
    w   = fx ? ((code == 0) ? 78 : code) : (3 * CLK) / (16 * bps);
    lim = CLK / bps - 1;
    return (w < lim) ? w : lim;
  endfunction

  function automatic longint b_start(input int k, input longint bps);
    return 1 + (k * CLK + bps - 1) / bps;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [2:0] sel,
                            input logic fx, input logic [11:0] wc,
                            input string tag);
    longint bps = b_bps(sel);
    longint w = b_width(bps, fx, longint'(wc));
    longint s [11];
    longint led_bad_n = -1, rdy_bad_n = -1;
    logic led_bad_a = 0, led_bad_e = 0, rdy_bad_a = 0, rdy_bad_e = 0;
    for (int k = 0; k < 11; k++) s[k] = b_start(k, bps);
    in_data = d; rate_sel = sel; mode_fixed = fx; fixed_width = wc;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (longint n = 0; n <= s[10]; n++) begin
      logic e_led;
      logic e_rdy;
      if (n > 0) @(negedge clk);
      if (n == 2) begin
        // R9: scramble configuration and offer another byte mid-frame
        rate_sel = 3'($urandom); mode_fixed = 1'($urandom);
        fixed_width = 12'($urandom); in_data = ~d; in_valid = 1'b1;
      end
      if (n == s[10] - 1) in_valid = 1'b0;
      e_led = 1'b0;
      for (int k = 0; k < 9; k++) begin
        logic b = (k == 0) ? 1'b0 : d[k-1];
        if (!b && n >= s[k] && n < s[k] + w) e_led = 1'b1;
      end
      e_rdy = (n >= s[10]);
      if (led_out !== e_led && led_bad_n < 0) begin
        led_bad_n = n; led_bad_a = led_out; led_bad_e = e_led;
      end
      if (in_ready !== e_rdy && rdy_bad_n < 0) begin
        rdy_bad_n = n; rdy_bad_a = in_ready; rdy_bad_e = e_rdy;
      end
    end
    check(led_bad_n < 0, tag, $sformatf("led waveform data=%02h cycle=%0d", d, led_bad_n),
          longint'(led_bad_a), longint'(led_bad_e));
    check(rdy_bad_n < 0, "R2", $sformatf("ready timing cycle=%0d", rdy_bad_n),
          longint'(rdy_bad_a), longint'(rdy_bad_e));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    repeat (50000) @(posedge clk);
    repeat (50000) @(posedge clk);
    repeat (40000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; failed++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(led_out === 1'b0, "R1", "led in reset", longint'(led_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1, "R1", "ready after reset", longint'(in_ready), 1);
    check(led_out === 1'b0, "R1", "led after reset", longint'(led_out), 0);

    send_frame(8'h00, 3'd6, 1'b1, 12'd0,    "R7");
    send_frame(8'h55, 3'd6, 1'b0, 12'd0,    "R6");
    send_frame(8'h0F, 3'd6, 1'b1, 12'd1000, "R8");
    send_frame(8'hFF, 3'd5, 1'b1, 12'd200,  "R3");
    send_frame(8'h12, 3'd7, 1'b0, 12'd0,    "R5");
    send_frame(8'h81, 3'd4, 1'b0, 12'd0,    "R9");
    send_frame(8'h3C, 3'd3, 1'b1, 12'd1,    "R4");
    send_frame(8'hA5, 3'd2, 1'b0, 12'd0,    "R5");
    for (int i = 0; i < 5; i++) begin
      logic [2:0] sel = (($urandom % 3) == 0) ? 3'd5 : 3'd6;
      send_frame(8'($urandom), sel, 1'($urandom), 12'($urandom % 600), "R4");
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

endmodule